// File: doc/BRIEF.md
# Bus Liveness Probe Controller

This block sits as a master on a shared system bus and proves that the bus still works. After each wait interval it reads two fixed addresses that a companion responder serves. The two reads must return bit patterns that are the complement of each other. The block then pulses the bus reset strobe and checks that the data lines read as all zeros. A failed step is repeated at once. When one step fails three times in a row, the block raises a sticky interrupt to the CPU and stops probing until software acknowledges it.

The bus is a simplified single-beat interface. A request lasts one cycle and carries an address. The response is a valid flag with a data word. The wait interval comes from a 16-bit period input. A small responder model ships with the block for test. It answers only the two probe addresses and has fault controls that let a bench corrupt answers, drop answers, or ignore the bus reset.

Top module: `bus_probe_ctrl`

## Requirements
- R1: After reset, or after a probe round completes, the block waits N cycles before its first read request, where N is the value on `period_i`. The first request appears N cycles after reset is released. After the round's reset strobe, the next request appears N+2 cycles later.
- R2: A `period_i` value of 0 is treated as 1.
- R3: A probe round runs in a fixed order: a read of address 1, then a read of address 2, then a bus reset strobe. Each read request holds `req_valid_o` high for exactly one cycle. The next step starts 2 cycles after the request when the responder answers in the following cycle.
- R4: The read of address 1 must return 0xAAAAAAAA and the read of address 2 must return 0x55555555. A wrong value is a failure, and the same read is issued again 2 cycles after the failed request.
- R5: `bus_reset_o` is a one-cycle strobe. `rsp_data_i` is sampled in the cycle after the strobe and must be zero. A nonzero value is a failure, and the strobe repeats 2 cycles after the previous strobe.
- R6: A read that gets no `rsp_valid_i` within 16 cycles is a failure. The retry request comes 17 cycles after the failed one.
- R7: Three consecutive failures of one step set `irq_o` 2 cycles after the third failing request or strobe, or 17 cycles after it on a timeout. `irq_phase_o` names the failing step: 0 = read of address 1, 1 = read of address 2, 2 = bus reset check.
- R8: The failure count clears when a step succeeds. Two failures, then a success, then two failures in the next step raise no interrupt.
- R9: `irq_o` stays high, and no request or strobe is issued, until `irq_ack_i` is pulsed. The acknowledge clears `irq_o` at the next edge. The first request of the new round follows N+1 cycles after the cycle in which the acknowledge was presented.
- R10: While reset is held, `req_valid_o`, `bus_reset_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 16 | Wait interval N between probe rounds |
| irq_ack_i | input | 1 | One-cycle interrupt acknowledge from the CPU |
| req_valid_o | output | 1 | Read request strobe |
| req_addr_o | output | 8 | Read request address |
| rsp_valid_i | input | 1 | Responder answer valid |
| rsp_data_i | input | 32 | Bus data lines |
| bus_reset_o | output | 1 | Bus reset strobe |
| irq_o | output | 1 | Sticky bus-fault interrupt |
| irq_phase_o | output | 2 | Step that caused the interrupt |

## Verification
Every observable event is given a due cycle, measured from the event before it:
- the first request is due N cycles after reset is released;
- a read that is answered leads to the next event 2 cycles later;
- a timed-out read leads to its retry 17 cycles later;
- the first request after the round's bus reset strobe is due N+2 cycles later;
- the first request after an acknowledge is due N+1 cycles later.

The scoreboard stores each expected event together with its gap. It takes the cycle count at the falling edge on which the event is seen and compares the measured gap, the event kind and the address or step code. An event that arrives while nothing is expected is an error. This rule is what catches a probe issued during the paused interval after an interrupt.

// File: rtl/bus_probe_pkg.sv
package bus_probe_pkg;

  typedef enum logic [2:0] {
    ST_COUNT = 3'd0,
    ST_REQ   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_BRST  = 3'd3,
    ST_BCHK  = 3'd4,
    ST_HALT  = 3'd5
  } probe_st_e;

  typedef enum logic [1:0] {
    PH_EVEN = 2'd0,
    PH_ODD  = 2'd1,
    PH_ZERO = 2'd2
  } probe_ph_e;

endpackage

// File: rtl/probe_responder.sv
module probe_responder #(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int ADDR_EVEN = 1,
  parameter int ADDR_ODD  = 2,
  parameter int BW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          bus_reset_i,
  input  logic [2:0]    flt_mask_i,
  input  logic          flt_mute_i,
  input  logic [BW-1:0] flt_count_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);

  localparam logic [DW-1:0] PAT_EVEN = {(DW/2){2'b10}};
  localparam logic [DW-1:0] PAT_ODD  = {(DW/2){2'b01}};
  localparam logic [BW-1:0] FOREVER  = '1;
  localparam logic [DW-1:0] FLIP     = {{(DW-1){1'b0}}, 1'b1};

  logic [BW-1:0] left_q [3];
  logic [2:0]    hit;
  logic [2:0]    bad;
  logic          ans_even, ans_odd;

  always_comb begin
    hit[0] = req_valid_i && !bus_reset_i && (req_addr_i == AW'(ADDR_EVEN));
    hit[1] = req_valid_i && !bus_reset_i && (req_addr_i == AW'(ADDR_ODD));
    hit[2] = bus_reset_i;
    for (int i = 0; i < 3; i++) begin
      bad[i] = hit[i] && flt_mask_i[i] && (left_q[i] != '0);
    end
    ans_even = hit[0] && !(bad[0] && flt_mute_i);
    ans_odd  = hit[1] && !(bad[1] && flt_mute_i);
  end

  for (genvar g = 0; g < 3; g++) begin : g_budget
    always_ff @(posedge clk) begin
      if (rst) begin
        left_q[g] <= flt_count_i;
      end else if (bad[g] && left_q[g] != FOREVER) begin
        left_q[g] <= left_q[g] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= ans_even || ans_odd;
      if (hit[2]) begin
        if (!bad[2]) rsp_data_o <= '0;
      end else if (ans_even) begin
        rsp_data_o <= bad[0] ? (PAT_EVEN ^ FLIP) : PAT_EVEN;
      end else if (ans_odd) begin
        rsp_data_o <= bad[1] ? (PAT_ODD ^ FLIP) : PAT_ODD;
      end
    end
  end

endmodule

// File: rtl/probe_period_timer.sv
module probe_period_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic [PW-1:0] period_i,
  output logic          done_o
);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] eff;

  always_comb begin
    eff    = (period_i == '0) ? PW'(1) : period_i;
    done_o = run_i && (cnt_q >= eff - PW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i || done_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  AST_COUNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> cnt_q == '0) else $error("timer not cleared"); // R1

endmodule

// File: rtl/probe_fail_counter.sv
module probe_fail_counter #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic pass_i,
  input  logic fail_i,
  output logic limit_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign limit_o = fail_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr_i || pass_i || limit_o) cnt_q <= '0;
    else if (fail_i)                       cnt_q <= cnt_q + 1'b1;
  end

  AST_FAIL_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(LIMIT)) else $error("fail count overflow"); // R7
  AST_PASS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    pass_i |=> cnt_q == '0) else $error("count kept after pass"); // R8

endmodule

// File: rtl/bus_probe_ctrl.sv
module bus_probe_ctrl
  import bus_probe_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 32,
  parameter int PW         = 16,
  parameter int TMO        = 16,
  parameter int FAIL_LIMIT = 3,
  parameter int ADDR_EVEN  = 1,
  parameter int ADDR_ODD   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] period_i,
  input  logic          irq_ack_i,
  output logic          req_valid_o,
  output logic [AW-1:0] req_addr_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          bus_reset_o,
  output logic          irq_o,
  output logic [1:0]    irq_phase_o
);

  localparam int            TW       = $clog2(TMO);
  localparam logic [DW-1:0] PAT_EVEN = {(DW/2){2'b10}};
  localparam logic [DW-1:0] PAT_ODD  = {(DW/2){2'b01}};

  probe_st_e     st_q;
  probe_ph_e     ph_q;
  logic [TW-1:0] wait_q;
  logic          per_done, tmo_hit, limit_hit;
  logic          chk_pass, chk_fail;
  logic [DW-1:0] expect_w;

  probe_period_timer #(.PW(PW)) u_period (
    .clk      (clk),
    .rst      (rst),
    .run_i    (st_q == ST_COUNT),
    .period_i (period_i),
    .done_o   (per_done)
  );

  probe_fail_counter #(.LIMIT(FAIL_LIMIT)) u_fails (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (st_q == ST_HALT),
    .pass_i  (chk_pass),
    .fail_i  (chk_fail),
    .limit_o (limit_hit)
  );

  always_comb begin
    expect_w = (ph_q == PH_EVEN) ? PAT_EVEN : PAT_ODD;
    tmo_hit  = (wait_q == TW'(TMO - 1));
    chk_pass = 1'b0;
    chk_fail = 1'b0;
    if (st_q == ST_WAIT) begin
      if (rsp_valid_i) begin
        chk_pass = (rsp_data_i == expect_w);
        chk_fail = (rsp_data_i != expect_w);
      end else begin
        chk_fail = tmo_hit;
      end
    end else if (st_q == ST_BCHK) begin
      chk_pass = (rsp_data_i == '0);
      chk_fail = (rsp_data_i != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_COUNT;
      ph_q        <= PH_EVEN;
      wait_q      <= '0;
      req_valid_o <= 1'b0;
      req_addr_o  <= '0;
      bus_reset_o <= 1'b0;
      irq_o       <= 1'b0;
      irq_phase_o <= 2'd0;
    end else begin
      req_valid_o <= 1'b0;
      bus_reset_o <= 1'b0;
      unique case (st_q)
        ST_COUNT: begin
          if (per_done) begin
            st_q        <= ST_REQ;
            ph_q        <= PH_EVEN;
            req_valid_o <= 1'b1;
            req_addr_o  <= AW'(ADDR_EVEN);
          end
        end
        ST_REQ: begin
          st_q   <= ST_WAIT;
          wait_q <= '0;
        end
        ST_BRST: st_q <= ST_BCHK;
        ST_WAIT, ST_BCHK: begin
          if (limit_hit) begin
            st_q        <= ST_HALT;
            irq_o       <= 1'b1;
            irq_phase_o <= ph_q;
          end else if (chk_fail) begin
            if (ph_q == PH_ZERO) begin
              st_q        <= ST_BRST;
              bus_reset_o <= 1'b1;
            end else begin
              st_q        <= ST_REQ;
              req_valid_o <= 1'b1;
            end
          end else if (chk_pass) begin
            unique case (ph_q)
              PH_EVEN: begin
                st_q        <= ST_REQ;
                ph_q        <= PH_ODD;
                req_valid_o <= 1'b1;
                req_addr_o  <= AW'(ADDR_ODD);
              end
              PH_ODD: begin
                st_q        <= ST_BRST;
                ph_q        <= PH_ZERO;
                bus_reset_o <= 1'b1;
              end
              default: st_q <= ST_COUNT;
            endcase
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        ST_HALT: begin
          if (irq_ack_i) begin
            irq_o <= 1'b0;
            st_q  <= ST_COUNT;
          end
        end
        default: st_q <= ST_COUNT;
      endcase
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |=> !req_valid_o) else $error("request longer than one cycle"); // R3
  AST_REQ_ADDR: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> (req_addr_o == AW'(ADDR_EVEN) || req_addr_o == AW'(ADDR_ODD)))
    else $error("bad probe address"); // R3
  AST_BRST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bus_reset_o |=> !bus_reset_o) else $error("reset strobe too long"); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_ack_i) |=> irq_o) else $error("interrupt dropped"); // R9
  AST_IRQ_PAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (!req_valid_o && !bus_reset_o)) else $error("probe while halted"); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irq_o && irq_ack_i) |=> !irq_o) else $error("ack ignored"); // R9

endmodule

// File: tb/bus_probe_ctrl_tb.sv
`timescale 1ns/1ps
module bus_probe_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rsp_rst = 1'b1;
  logic [15:0] period = 16'd5;
  logic        ack = 1'b0;
  logic [2:0]  flt_mask = 3'b000;
  logic        flt_mute = 1'b0;
  logic [3:0]  flt_count = 4'd0;
  logic        req_valid, bus_reset, irq, rsp_valid;
  logic [7:0]  req_addr;
  logic [31:0] rsp_data;
  logic [1:0]  irq_phase;

  always #2.5 clk = ~clk;

  bus_probe_ctrl u_dut (
    .clk(clk), .rst(rst), .period_i(period), .irq_ack_i(ack),
    .req_valid_o(req_valid), .req_addr_o(req_addr),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .bus_reset_o(bus_reset), .irq_o(irq), .irq_phase_o(irq_phase)
  );

  probe_responder u_rsp (
    .clk(clk), .rst(rsp_rst), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .bus_reset_i(bus_reset), .flt_mask_i(flt_mask), .flt_mute_i(flt_mute),
    .flt_count_i(flt_count), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
  );

  typedef struct {
    int    kind;
    int    val;
    int    gap;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0, last = 0, n_chk = 0, n_fail = 0;
  bit   mon_en = 1'b0;
  logic irq_q = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int k, int v, int g, string t);
    exp_t e;
    e.kind = k; e.val = v; e.gap = g; e.tag = t;
    q.push_back(e);
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic note(int k, int v);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, irq ? "R9" : "R3", "unexpected event kind", k, -1);
    end else begin
      e = q.pop_front();
      check(e.kind == k, e.tag, "event kind", k, e.kind);
      check(e.val == v, e.tag, "event value", v, e.val);
      check(e.gap == cyc - last, e.tag, "event gap", cyc - last, e.gap);
    end
    last = cyc;
  endtask

  // monitor: 0 = read request (value = address), 1 = bus reset strobe, 2 = interrupt (value = step)
  initial forever begin
    @(negedge clk);
    if (mon_en) begin
      if (req_valid) note(0, int'(req_addr));
      if (bus_reset) note(1, 0);
      if (irq && !irq_q) note(2, int'(irq_phase));
    end
    irq_q = irq;
  end

  task automatic start(int per, logic [2:0] m, logic mute, logic [3:0] c);
    mon_en = 1'b0;
    rst = 1'b1; rsp_rst = 1'b1;
    period = 16'(per); flt_mask = m; flt_mute = mute; flt_count = c;
    repeat (3) @(negedge clk);
    q.delete();
  endtask

  task automatic go();
    @(negedge clk);
    rst = 1'b0; rsp_rst = 1'b0;
    last = cyc; irq_q = 1'b0; mon_en = 1'b1;
  endtask

  task automatic drain();
    int w = 0;
    while (q.size() != 0 && w < 400) begin
      @(negedge clk);
      w++;
    end
    check(q.size() == 0, "R3", "watchdog, pending events", q.size(), 0);
  endtask

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R10: reset state
    start(5, 3'b000, 1'b0, 4'd0);
    check(!req_valid, "R10", "req_valid in reset", req_valid, 0);
    check(!bus_reset, "R10", "bus_reset in reset", bus_reset, 0);
    check(!irq, "R10", "irq in reset", irq, 0);

    // R1 R3 R4: healthy rounds, period 5
    push(0, 1, 5, "R1"); push(0, 2, 2, "R3"); push(1, 0, 2, "R3");
    push(0, 1, 7, "R1"); push(0, 2, 2, "R4"); push(1, 0, 2, "R3");
    go(); drain();

    // R2: period 0 acts as 1
    start(0, 3'b000, 1'b0, 4'd0);
    push(0, 1, 1, "R2"); push(0, 2, 2, "R2"); push(1, 0, 2, "R2"); push(0, 1, 3, "R2");
    go(); drain();

    // R4 R7 R9: address 1 always corrupt, then pause, then acknowledge
    start(3, 3'b001, 1'b0, 4'hF);
    push(0, 1, 3, "R4"); push(0, 1, 2, "R4"); push(0, 1, 2, "R4"); push(2, 0, 2, "R7");
    go(); drain();
    repeat (40) @(negedge clk);
    check(irq == 1'b1, "R9", "irq held while unacknowledged", irq, 1);
    rsp_rst = 1'b1; flt_mask = 3'b000;
    @(negedge clk); rsp_rst = 1'b0;
    push(0, 1, 4, "R9"); push(0, 2, 2, "R9"); push(1, 0, 2, "R9");
    @(negedge clk); ack = 1'b1; last = cyc;
    @(negedge clk); ack = 1'b0;
    check(irq == 1'b0, "R9", "irq after ack", irq, 0);
    drain();

    // R8 R5: two failures on address 2 and on the reset check, no interrupt
    start(4, 3'b110, 1'b0, 4'd2);
    push(0, 1, 4, "R8"); push(0, 2, 2, "R8"); push(0, 2, 2, "R8"); push(0, 2, 2, "R8");
    push(1, 0, 2, "R5"); push(1, 0, 2, "R5"); push(1, 0, 2, "R8"); push(0, 1, 6, "R8");
    go(); drain();
    check(irq == 1'b0, "R8", "no irq after recovered failures", irq, 0);

    // R6: address 1 never answers
    start(3, 3'b001, 1'b1, 4'hF);
    push(0, 1, 3, "R6"); push(0, 1, 17, "R6"); push(0, 1, 17, "R6"); push(2, 0, 17, "R6");
    go(); drain();

    // R5 R7: bus never resets
    start(3, 3'b100, 1'b0, 4'hF);
    push(0, 1, 3, "R5"); push(0, 2, 2, "R5"); push(1, 0, 2, "R5");
    push(1, 0, 2, "R5"); push(1, 0, 2, "R5"); push(2, 2, 2, "R7");
    go(); drain();

    // R7: address 2 always corrupt
    start(3, 3'b010, 1'b0, 4'hF);
    push(0, 1, 3, "R7"); push(0, 2, 2, "R7"); push(0, 2, 2, "R7");
    push(0, 2, 2, "R7"); push(2, 1, 2, "R7");
    go(); drain();
    check(irq_phase == 2'd1, "R7", "irq_phase for address 2", irq_phase, 1);

    mon_en = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule